// File: doc/BRIEF.md
# Banked Register-File Address Mapper

This block is the data-memory side of a small 8-bit controller. It takes an 8-bit direct address, plus a second access path that addresses memory through one of two 8-bit pointers. It steers each access to one of four stores:

- a handful of special registers;
- a 48-byte common area that every bank sees;
- a 64-entry I/O register file;
- a 4096-byte general-purpose RAM.

The direct and pointer paths reach the same RAM bytes.

Two bank registers shape the mapping. The direct bank register supplies the upper five RAM address bits for the upper half of the direct address space. Its lowest three bits select an I/O group for the restricted move instructions. The indirect bank register holds one 4-bit bank field for each pointer, so the two pointers can address two different 256-byte windows of RAM at the same time.

Reads on both ports are combinational from the stored state. Writes happen on the rising clock edge.

Top module: `banked_regmap`

## Requirements
- R1: During reset and right after it, the direct bank register, the indirect bank register and the product pair all read as 0x00.
- R2: Direct address 0x00 is the direct bank register and 0x01 is the indirect bank register. Both can be read and written. A new value steers the very next access.
- R3: Direct address 0x02 is the product low byte and 0x03 is the product high byte, both plain read/write storage. Addresses 0x04–0x0F read 0x00, and writes to them are ignored.
- R4: Direct addresses 0x10–0x3F form a 48-byte common RAM. Neither bank register nor the restricted flag affects it.
- R5: For an ordinary direct access (restricted flag low), addresses 0x40–0x7F reach I/O register number (addr − 0x40).
- R6: For a restricted access in 0x40–0x7F, the I/O register number is {direct bank[2:0], addr[2:0]}, and addr[5:3] is ignored. This holds for both reads and writes.
- R7: Direct addresses 0x80–0xFF reach RAM byte {direct bank[7:3], addr[6:0]}.
- R8: A pointer access with pointer select 0 reaches RAM byte {indirect bank[3:0], pointer}.
- R9: A pointer access with pointer select 1 reaches RAM byte {indirect bank[7:4], pointer}. Each pointer's bank field is independent of the other's.
- R10: The two ports share the RAM. A byte written through one port reads back through the other wherever the addresses resolve to the same RAM byte.
- R11: If both ports write in the same cycle, the indirect port's data wins when they hit the same RAM byte. When they hit different bytes, both bytes are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_addr | input | 8 | Direct address |
| d_restricted | input | 1 | Marks a restricted move instruction |
| d_we | input | 1 | Direct write enable |
| d_wdata | input | 8 | Direct write data |
| d_rdata | output | 8 | Direct read data, combinational |
| ind_sel | input | 1 | Pointer select: 0 or 1 |
| ind_ptr | input | 8 | Value of the selected pointer |
| ind_we | input | 1 | Indirect write enable |
| ind_wdata | input | 8 | Indirect write data |
| ind_rdata | output | 8 | Indirect read data, combinational |

## Verification
The hardest state to reach from the ports is a same-cycle write collision on one RAM byte. The direct path forms its address from five bank bits and seven offset bits. The pointer path forms its address from four bank bits and eight pointer bits. The stimulus first programs both bank registers so that the two addresses meet: direct bank 0x38 and indirect bank low nibble 3 both land in the 0x380 region. It then drives both write enables in one cycle, at an equal byte and at neighbouring bytes.

Full sweeps write the whole RAM through each pointer in turn and read it back through the direct banked window and through the other pointer. This exposes any slip in a bank field or a pointer nibble.

// File: rtl/banked_regmap.sv
module banked_regmap (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] d_addr,
  input  logic       d_restricted,
  input  logic       d_we,
  input  logic [7:0] d_wdata,
  output logic [7:0] d_rdata,
  input  logic       ind_sel,
  input  logic [7:0] ind_ptr,
  input  logic       ind_we,
  input  logic [7:0] ind_wdata,
  output logic [7:0] ind_rdata
);
  localparam int IND_BANK_W = 4;
  localparam int RAM_AW     = IND_BANK_W + 8;
  localparam int RAM_DEPTH  = 1 << RAM_AW;
  localparam int COMMON_N   = 48;
  localparam int IO_N       = 64;

  logic [7:0] dbank, ibank, prod_lo, prod_hi;
  logic [7:0] ram    [RAM_DEPTH];
  logic [7:0] common [COMMON_N];
  logic [7:0] io     [IO_N];

  wire in_sfr    = d_addr[7:4] == 4'h0;
  wire in_common = d_addr[7:6] == 2'b00 && d_addr[5:4] != 2'b00;
  wire in_io     = d_addr[7:6] == 2'b01;
  wire in_bank   = d_addr[7];

  wire [5:0]        io_idx  = d_restricted ? {dbank[2:0], d_addr[2:0]} : d_addr[5:0];
  wire [5:0]        com_idx = d_addr[5:0] - 6'h10;
  wire [RAM_AW-1:0] d_phys  = {dbank[7:3], d_addr[6:0]};
  wire [IND_BANK_W-1:0] i_bank = ind_sel ? ibank[7:4] : ibank[3:0];
  wire [RAM_AW-1:0] i_phys  = {i_bank, ind_ptr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbank   <= 8'h00;
      ibank   <= 8'h00;
      prod_lo <= 8'h00;
      prod_hi <= 8'h00;
    end else if (d_we && in_sfr) begin
      case (d_addr[3:0])
        4'h0:    dbank   <= d_wdata;
        4'h1:    ibank   <= d_wdata;
        4'h2:    prod_lo <= d_wdata;
        4'h3:    prod_hi <= d_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (d_we && in_bank)   ram[d_phys] <= d_wdata;
    if (ind_we)            ram[i_phys] <= ind_wdata;
    if (d_we && in_common) common[com_idx] <= d_wdata;
    if (d_we && in_io)     io[io_idx] <= d_wdata;
  end

  always_comb begin
    d_rdata = 8'h00;
    if (in_bank)        d_rdata = ram[d_phys];
    else if (in_io)     d_rdata = io[io_idx];
    else if (in_common) d_rdata = common[com_idx];
    else begin
      case (d_addr[3:0])
        4'h0:    d_rdata = dbank;
        4'h1:    d_rdata = ibank;
        4'h2:    d_rdata = prod_lo;
        4'h3:    d_rdata = prod_hi;
        default: d_rdata = 8'h00;
      endcase
    end
  end

  assign ind_rdata = ram[i_phys];

  AST_BANK_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dbank == 8'h00 && ibank == 8'h00)); // R1
  AST_DBANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (d_we && d_addr == 8'h00) |=> dbank == $past(d_wdata)); // R2
  AST_DBANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_we && d_addr == 8'h00) |=> $stable(dbank)); // R2
  AST_IBANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_we && d_addr == 8'h01) |=> $stable(ibank)); // R2
  AST_SFR_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (d_addr[7:4] == 4'h0 && d_addr[3:2] != 2'b00) |-> d_rdata == 8'h00); // R3
  AST_COMMON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (d_we && in_common) |=> common[$past(com_idx)] == $past(d_wdata)); // R4
  AST_IO_RESTRICTED: assert property (@(posedge clk) disable iff (!rst_n)
    (d_we && d_restricted && in_io) |=>
      io[{$past(dbank[2:0]), $past(d_addr[2:0])}] == $past(d_wdata)); // R6
  AST_IND_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_we && d_we && in_bank && d_phys == i_phys) |=>
      ram[$past(i_phys)] == $past(ind_wdata)); // R11
endmodule

// File: tb/test_banked_regmap.sv
module test_banked_regmap;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] d_addr = 8'h00, d_wdata = 8'h00, ind_ptr = 8'h00, ind_wdata = 8'h00;
  logic d_restricted = 1'b0, d_we = 1'b0, ind_sel = 1'b0, ind_we = 1'b0;
  logic [7:0] d_rdata, ind_rdata;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  banked_regmap i_banked_regmap (
    .clk(clk), .rst_n(rst_n), .d_addr(d_addr), .d_restricted(d_restricted),
    .d_we(d_we), .d_wdata(d_wdata), .d_rdata(d_rdata), .ind_sel(ind_sel),
    .ind_ptr(ind_ptr), .ind_we(ind_we), .ind_wdata(ind_wdata), .ind_rdata(ind_rdata));

  function automatic logic [7:0] pat_a(input int p);
    return 8'((p * 7 + (p >> 8) * 13) & 255);
  endfunction
  function automatic logic [7:0] pat_b(input int p);
    return 8'(((p * 3 + 91) ^ (p >> 8)) & 255);
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic dwr(input logic [7:0] a, input logic [7:0] d, input logic r);
    @(negedge clk);
    d_addr = a; d_wdata = d; d_restricted = r; d_we = 1'b1; ind_we = 1'b0;
    @(posedge clk); #1;
    d_we = 1'b0;
  endtask

  task automatic iwr(input logic s, input logic [7:0] p, input logic [7:0] d);
    @(negedge clk);
    ind_sel = s; ind_ptr = p; ind_wdata = d; ind_we = 1'b1; d_we = 1'b0;
    @(posedge clk); #1;
    ind_we = 1'b0;
  endtask

  task automatic both_wr(input logic [7:0] a, input logic [7:0] dd,
                         input logic s, input logic [7:0] p, input logic [7:0] id);
    @(negedge clk);
    d_addr = a; d_wdata = dd; d_restricted = 1'b0; d_we = 1'b1;
    ind_sel = s; ind_ptr = p; ind_wdata = id; ind_we = 1'b1;
    @(posedge clk); #1;
    d_we = 1'b0; ind_we = 1'b0;
  endtask

  task automatic dchk(input logic [7:0] a, input logic r, input logic [7:0] exp, input string tag);
    @(negedge clk);
    d_addr = a; d_restricted = r; d_we = 1'b0; ind_we = 1'b0;
    #2;
    chk(d_rdata, exp, tag);
  endtask

  task automatic ichk(input logic s, input logic [7:0] p, input logic [7:0] exp, input string tag);
    @(negedge clk);
    ind_sel = s; ind_ptr = p; d_we = 1'b0; ind_we = 1'b0;
    #2;
    chk(ind_rdata, exp, tag);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(d_rdata, 8'h00, "R1 reset read");
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 4; a++) dchk(8'(a), 1'b0, 8'h00, "R1 reset state");

    // R8: fill all RAM through pointer 0; R7/R10: read through the direct banked window
    for (int b = 0; b < 16; b++) begin
      dwr(8'h01, 8'(b), 1'b0);
      for (int p = 0; p < 256; p++) iwr(1'b0, 8'(p), pat_a(b * 256 + p));
    end
    for (int hb = 0; hb < 32; hb++) begin
      dwr(8'h00, 8'((hb << 3) | (hb & 7)), 1'b0);
      for (int o = 0; o < 128; o++) dchk(8'(8'h80 | o), 1'b0, pat_a(hb * 128 + o), "R7 R10 banked read");
    end
    for (int b = 0; b < 16; b++) begin
      dwr(8'h01, 8'((b << 4) | (15 - b)), 1'b0);
      for (int p = 0; p < 256; p += 17) ichk(1'b0, 8'(p), pat_a((15 - b) * 256 + p), "R8 pointer0 read");
    end

    // R9: fill through pointer 1, read back through both pointers with different nibbles
    for (int b = 0; b < 16; b++) begin
      dwr(8'h01, 8'((b << 4) | (b ^ 5)), 1'b0);
      for (int p = 0; p < 256; p++) iwr(1'b1, 8'(p), pat_b(b * 256 + p));
    end
    for (int b = 0; b < 16; b++) begin
      dwr(8'h01, 8'(((15 - b) << 4) | b), 1'b0);
      for (int p = 0; p < 256; p++) begin
        ichk(1'b0, 8'(p), pat_b(b * 256 + p), "R9 pointer0 sees pointer1 data");
        ichk(1'b1, 8'(p), pat_b((15 - b) * 256 + p), "R9 pointer1 independent bank");
      end
    end
    for (int hb = 0; hb < 32; hb += 3) begin
      dwr(8'h00, 8'(hb << 3), 1'b0);
      for (int o = 0; o < 128; o += 5) dchk(8'(8'h80 | o), 1'b0, pat_b(hb * 128 + o), "R10 direct sees pointer data");
    end

    // R2: bank register readback and next-access effect
    dwr(8'h00, 8'h5B, 1'b0);
    dchk(8'h00, 1'b0, 8'h5B, "R2 direct bank readback");
    dwr(8'h01, 8'hC4, 1'b0);
    dchk(8'h01, 1'b0, 8'hC4, "R2 indirect bank readback");
    dwr(8'h00, 8'h90, 1'b0);
    dchk(8'h85, 1'b0, pat_b(18 * 128 + 5), "R2 next access uses new bank");

    // R4: common RAM, unaffected by bank registers and the restricted flag
    dwr(8'h00, 8'hA5, 1'b0);
    for (int a = 16; a < 64; a++) dwr(8'(a), 8'(a ^ 8'h5C), 1'b0);
    dwr(8'h00, 8'h3A, 1'b0);
    dwr(8'h01, 8'hC3, 1'b0);
    for (int o = 0; o < 64; o++) dwr(8'(8'h80 | o), 8'hFF, 1'b0);
    for (int a = 16; a < 64; a++) dchk(8'(a), 1'(a & 1), 8'(a ^ 8'h5C), "R4 common RAM");

    // R3: product pair and reserved special addresses
    dwr(8'h02, 8'h9E, 1'b0);
    dwr(8'h03, 8'h61, 1'b0);
    for (int a = 4; a < 16; a++) dwr(8'(a), 8'hFF, 1'b0);
    dchk(8'h02, 1'b0, 8'h9E, "R3 product low");
    dchk(8'h03, 1'b0, 8'h61, "R3 product high");
    for (int a = 4; a < 16; a++) dchk(8'(a), 1'b0, 8'h00, "R3 reserved reads zero");
    dchk(8'h00, 1'b0, 8'h3A, "R3 reserved write left bank intact");

    // R5: ordinary I/O access by full address
    for (int k = 0; k < 64; k++) dwr(8'(8'h40 + k), 8'(k * 5 + 3), 1'b0);
    for (int k = 0; k < 64; k++) dchk(8'(8'h40 + k), 1'b0, 8'(k * 5 + 3), "R5 I/O ordinary");

    // R6: restricted access sees only the group from the bank register
    for (int g = 0; g < 8; g++) begin
      dwr(8'h00, 8'({5'b10110, 3'(g)}), 1'b0);
      for (int k = 0; k < 64; k++) dchk(8'(8'h40 + k), 1'b1, 8'((g * 8 + (k % 8)) * 5 + 3), "R6 restricted read");
    end
    dwr(8'h00, 8'h05, 1'b0);
    for (int i = 0; i < 8; i++) dwr(8'(8'h40 + ((i * 3) % 8) * 8 + i), 8'(8'hE0 + i), 1'b1);
    for (int i = 0; i < 8; i++) dchk(8'(8'h68 + i), 1'b0, 8'(8'hE0 + i), "R6 restricted write group");
    for (int i = 0; i < 8; i++) dchk(8'(8'h40 + i), 1'b0, 8'(i * 5 + 3), "R6 other group untouched");

    // R11: same-cycle write collision
    dwr(8'h00, 8'h38, 1'b0);
    dwr(8'h01, 8'h03, 1'b0);
    both_wr(8'h85, 8'h11, 1'b0, 8'h85, 8'h22);
    dchk(8'h85, 1'b0, 8'h22, "R11 indirect wins same byte");
    ichk(1'b0, 8'h85, 8'h22, "R11 indirect wins via pointer");
    both_wr(8'h86, 8'h33, 1'b0, 8'h87, 8'h44);
    dchk(8'h86, 1'b0, 8'h33, "R11 direct byte written");
    dchk(8'h87, 1'b0, 8'h44, "R11 indirect byte written");
    dwr(8'h01, 8'h30, 1'b0);
    both_wr(8'hF0, 8'h55, 1'b1, 8'hF0, 8'h66);
    dchk(8'hF0, 1'b0, 8'h66, "R11 pointer1 wins same byte");

    finish_run();
  end
endmodule